// File: doc/BRIEF.md
# Multi-Turn Gray Word Assembler

This block turns the code patterns of a stack of reduction gear wheels into one multi-turn position word in Gray code. Each wheel supplies a 3-bit code. The wheels turn at successive quarter ratios, so their codes are ambiguous near each transition because of gear play. The block resolves that ambiguity with a chain of select-steered cells. The first cell is steered by the most significant bit of the companion single-turn position. Each later cell is steered by a bit that the cell below it derives, so a wheel is read correctly as long as its slower neighbour is misaligned by less than a quarter of its own step.

A strobe marks the instant at which the single-turn position is read. Only on that strobe does the assembled word enter the output register, together with its binary equivalent. The multi-turn and single-turn halves of the position therefore always belong to the same moment. A valid flag is raised for the cycle that follows each strobe.

The number of active wheels is chosen at run time. Wheel pairs above that count read as zero, which gives resolution in steps of two bits.

A two-state controller runs the output side:
- `ST_IDLE`: the output register holds its value.
- `ST_PUBLISH`: a word has just been loaded.

Its transitions are:
- `ST_IDLE -> ST_PUBLISH` on a strobe.
- `ST_PUBLISH -> ST_PUBLISH` on a further strobe.
- `ST_PUBLISH -> ST_IDLE` when no strobe is present.

Top module: `mt_gray_assembler`

## Requirements
- R1: While reset is low and in the first cycle after reset, `valid_o` is 0 and `gray_o` and `bin_o` are all zero.
- R2: Wheel k (k = 1..7) takes its code from `wheel_code_i[3k-1:3k-3]`, whose bit 2 is c2, bit 1 is c1 and bit 0 is c0. The select of wheel 1 is `st_msb_i`. With select s, wheel k produces three bits:
  - V = s ? c2 : ~c2
  - Dh = s ? c1 : ~c1
  - Dl = s ? (c0^c1) : ~(c0^c1)
- R3: The V bit of wheel k is the select of wheel k+1. For example, all codes 0 with `st_msb_i`=0 and all seven wheels active gives gray 14'h3333, and the same codes with `st_msb_i`=1 give 14'h0CCC.
- R4: Wheel k places Dh on gray bit 2k-1 and Dl on gray bit 2k-2.
- R5: With `active_wheels_i` = n, gray bits 2n and above are 0:
  - n=6 turns 14'h3333 into 14'h0333.
  - n=0 gives an all-zero word.
  - n=7 masks nothing.
- R6: Bit i of `bin_o` equals the XOR of the masked Gray bits from bit 13 down to bit i.
- R7: `gray_o` and `bin_o` change only at a clock edge where `strobe_i` is 1. At such an edge they load the word formed from the inputs present at that edge. Otherwise they hold, whatever the wheel codes, select or count do.
- R8: `valid_o` is 1 in exactly the cycles that follow an edge where `strobe_i` was 1, so back-to-back strobes keep it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_i | input | 1 | Single-turn read instant; loads the output register |
| st_msb_i | input | 1 | MSB of the single-turn position, select for wheel 1 |
| wheel_code_i | input | 21 | Seven 3-bit wheel codes, wheel 1 in the low bits |
| active_wheels_i | input | 3 | Number of active wheels, 0..7 |
| gray_o | output | 14 | Registered masked multi-turn Gray word |
| bin_o | output | 14 | Registered binary form of `gray_o` |
| valid_o | output | 1 | One-cycle flag after each strobe |

## Verification
Every result is due one clock after the edge that samples the strobe: `gray_o`, `bin_o` and `valid_o` all come from a single register stage, and the assembly logic in front of it is purely combinational. The bench drives inputs shortly after a rising edge and updates its reference model at the same edges. It compares all three outputs at each falling edge, so each output is seen half a period after the edge that should have changed it. Directed checks read the outputs at the falling edge right after the capturing edge. The hold checks change the inputs with the strobe low and read the outputs over the following cycles.

// File: rtl/mtg_pkg.sv
`timescale 1ns/1ps
package mtg_pkg;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_PUBLISH = 1'b1
    } pub_state_e;

    typedef struct packed {
        logic v;
        logic d_hi;
        logic d_lo;
    } cell_out_t;

endpackage

// File: rtl/mtg_gear_cell.sv
`timescale 1ns/1ps
module mtg_gear_cell
    import mtg_pkg::*;
(
    input  logic       sel_i,
    input  logic [2:0] code_i,
    output cell_out_t  out_o
);
    logic flip;
    logic parity;

    always_comb begin
        flip         = ~sel_i;
        parity       = code_i[0] ^ code_i[1];
        out_o.v      = flip ? ~code_i[2] : code_i[2];
        out_o.d_hi   = flip ? ~code_i[1] : code_i[1];
        out_o.d_lo   = flip ? ~parity    : parity;
    end
endmodule

// File: rtl/mtg_gear_chain.sv
`timescale 1ns/1ps
module mtg_gear_chain
    import mtg_pkg::*;
#(
    parameter int NUM_WHEELS = 7,
    localparam int CODE_W    = 3 * NUM_WHEELS,
    localparam int GW        = 2 * NUM_WHEELS,
    localparam int CW        = $clog2(NUM_WHEELS + 1)
) (
    input  logic              anchor_sel_i,
    input  logic [CODE_W-1:0] codes_i,
    input  logic [CW-1:0]     active_i,
    output logic [GW-1:0]     gray_o
);
    logic      [NUM_WHEELS:0] sel_chain;
    cell_out_t                cells [NUM_WHEELS];

    assign sel_chain[0] = anchor_sel_i;

    for (genvar k = 0; k < NUM_WHEELS; k++) begin : g_wheel
        mtg_gear_cell u_cell (
            .sel_i  (sel_chain[k]),
            .code_i (codes_i[3*k +: 3]),
            .out_o  (cells[k])
        );
        assign sel_chain[k+1] = cells[k].v;
        assign gray_o[2*k +: 2] = (active_i > CW'(k)) ?
                                  {cells[k].d_hi, cells[k].d_lo} : 2'b00;
    end

    // R3: the select handed upward and the upper data bit are steered together
    always_comb begin
        for (int k = 0; k < NUM_WHEELS; k++) begin
            a_r3_link: assert ((sel_chain[k+1] ^ cells[k].d_hi) ==
                               (codes_i[3*k+2] ^ codes_i[3*k+1]));
        end
    end
endmodule

// File: rtl/mtg_gray2bin.sv
`timescale 1ns/1ps
module mtg_gray2bin #(
    parameter int W = 14
) (
    input  logic [W-1:0] gray_i,
    output logic [W-1:0] bin_o
);
    logic acc;

    always_comb begin
        acc = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            acc      = acc ^ gray_i[i];
            bin_o[i] = acc;
        end
    end
endmodule

// File: rtl/mt_gray_assembler.sv
`timescale 1ns/1ps
module mt_gray_assembler
    import mtg_pkg::*;
#(
    parameter int NUM_WHEELS = 7,
    localparam int CODE_W    = 3 * NUM_WHEELS,
    localparam int GW        = 2 * NUM_WHEELS,
    localparam int CW        = $clog2(NUM_WHEELS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_i,
    input  logic              st_msb_i,
    input  logic [CODE_W-1:0] wheel_code_i,
    input  logic [CW-1:0]     active_wheels_i,
    output logic [GW-1:0]     gray_o,
    output logic [GW-1:0]     bin_o,
    output logic              valid_o
);
    pub_state_e      state_q;
    pub_state_e      state_d;
    logic [GW-1:0]   gray_word;
    logic [GW-1:0]   bin_word;

    mtg_gear_chain #(.NUM_WHEELS(NUM_WHEELS)) u_chain (
        .anchor_sel_i (st_msb_i),
        .codes_i      (wheel_code_i),
        .active_i     (active_wheels_i),
        .gray_o       (gray_word)
    );

    mtg_gray2bin #(.W(GW)) u_conv (
        .gray_i (gray_word),
        .bin_o  (bin_word)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (strobe_i) state_d = ST_PUBLISH;
            ST_PUBLISH: state_d = strobe_i ? ST_PUBLISH : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gray_o <= '0;
            bin_o  <= '0;
        end else if (strobe_i) begin
            gray_o <= gray_word;
            bin_o  <= bin_word;
        end
    end

    assign valid_o = (state_q == ST_PUBLISH);

    a_r8_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i |=> valid_o);

    a_r8_valid_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(strobe_i));

    a_r7_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> ($stable(gray_o) && $stable(bin_o)));

    a_r6_bin_inverse: assert property (@(posedge clk) disable iff (!rst_n)
        gray_o == (bin_o ^ (bin_o >> 1)));

    for (genvar k = 0; k < NUM_WHEELS; k++) begin : g_mask_chk
        a_r5_mask_pair: assert property (@(posedge clk) disable iff (!rst_n)
            (strobe_i && (active_wheels_i <= CW'(k))) |=> (gray_o[2*k +: 2] == 2'b00));
    end
endmodule

// File: tb/mt_gray_assembler_tb_top.sv
`timescale 1ns/1ps
module mt_gray_assembler_tb_top;
    localparam int NW = 7;
    localparam int CWD = 3 * NW;
    localparam int GW = 2 * NW;
    localparam int CW = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           strobe_i = 1'b0;
    logic           st_msb_i = 1'b0;
    logic [CWD-1:0] wheel_code_i = '0;
    logic [CW-1:0]  active_wheels_i = 3'd7;
    logic [GW-1:0]  gray_o;
    logic [GW-1:0]  bin_o;
    logic           valid_o;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    logic [GW-1:0] exp_gray = '0;
    logic [GW-1:0] exp_bin = '0;
    logic          exp_valid = 1'b0;

    always #4 clk = ~clk;

    mt_gray_assembler dut_i (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .st_msb_i(st_msb_i),
        .wheel_code_i(wheel_code_i), .active_wheels_i(active_wheels_i),
        .gray_o(gray_o), .bin_o(bin_o), .valid_o(valid_o)
    );

    function automatic logic [GW-1:0] ref_gray(input logic [CWD-1:0] c,
                                               input logic msb, input int act);
        logic [GW-1:0] g = '0;
        logic s = msb;
        for (int k = 0; k < NW; k++) begin
            logic c2 = c[3*k+2];
            logic c1 = c[3*k+1];
            logic c0 = c[3*k];
            logic v  = s ? c2 : !c2;
            logic dh = s ? c1 : !c1;
            logic dl = s ? (c0 ^ c1) : !(c0 ^ c1);
            if (k < act) begin
                g[2*k+1] = dh;
                g[2*k]   = dl;
            end
            s = v;
        end
        return g;
    endfunction

    function automatic logic [GW-1:0] ref_bin(input logic [GW-1:0] g);
        logic [GW-1:0] b;
        for (int i = 0; i < GW; i++) begin
            logic x = 1'b0;
            for (int j = i; j < GW; j++) x = x ^ g[j];
            b[i] = x;
        end
        return b;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [GW-1:0] act, input logic [GW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_gray  <= '0;
            exp_bin   <= '0;
            exp_valid <= 1'b0;
        end else begin
            exp_valid <= strobe_i;
            if (strobe_i) begin
                exp_gray <= ref_gray(wheel_code_i, st_msb_i, int'(active_wheels_i));
                exp_bin  <= ref_bin(ref_gray(wheel_code_i, st_msb_i, int'(active_wheels_i)));
            end
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            check("R7", "gray per cycle", gray_o, exp_gray);
            check("R6", "bin per cycle", bin_o, exp_bin);
            check("R8", "valid per cycle", GW'(valid_o), GW'(exp_valid));
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic strobe_word(input logic [CWD-1:0] c, input logic msb, input logic [CW-1:0] act);
        @(posedge clk); #2;
        wheel_code_i = c; st_msb_i = msb; active_wheels_i = act; strobe_i = 1'b1;
        @(posedge clk); #2;
        strobe_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #1_200_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [GW-1:0] held;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "gray in reset", gray_o, '0);
        check("R1", "valid in reset", GW'(valid_o), '0);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check("R1", "bin after reset", bin_o, '0);
        check("R1", "valid after reset", GW'(valid_o), '0);
        cmp_en = 1'b1;

        // R2 R3 R4: known chain words
        strobe_word('0, 1'b0, 3'd7);
        check("R3", "all-zero codes msb0", gray_o, 14'h3333);
        check("R8", "valid after strobe", GW'(valid_o), 14'd1);
        strobe_word('0, 1'b1, 3'd7);
        check("R3", "all-zero codes msb1", gray_o, 14'h0CCC);
        // R2 R4: wheel 1 with c=3'b011, msb1 -> Dh=1, Dl=0
        strobe_word(21'h000003, 1'b1, 3'd7);
        check("R4", "wheel1 bits", GW'(gray_o[1:0]), 14'd2);
        check("R2", "wheel1 word", gray_o, ref_gray(21'h000003, 1'b1, 7));

        // R5 masking
        strobe_word('0, 1'b0, 3'd6);
        check("R5", "six wheels", gray_o, 14'h0333);
        strobe_word('0, 1'b0, 3'd0);
        check("R5", "zero wheels", gray_o, 14'h0000);
        check("R6", "zero wheels bin", bin_o, 14'h0000);
        strobe_word(21'h1ABCDE, 1'b1, 3'd1);
        check("R5", "one wheel", gray_o & 14'h3FFC, 14'h0000);

        // R6 binary form
        strobe_word('0, 1'b0, 3'd7);
        check("R6", "bin of 3333", bin_o, ref_bin(14'h3333));

        // R7 hold with strobe low
        held = gray_o;
        @(posedge clk); #2;
        wheel_code_i = 21'h15A5A5; st_msb_i = 1'b1; active_wheels_i = 3'd3;
        repeat (3) @(negedge clk);
        check("R7", "hold gray", gray_o, held);
        check("R8", "valid drops", GW'(valid_o), '0);

        // R8 back-to-back strobes
        @(posedge clk); #2;
        strobe_i = 1'b1;
        @(posedge clk); #2;
        @(negedge clk);
        check("R8", "valid b2b first", GW'(valid_o), 14'd1);
        @(negedge clk);
        check("R8", "valid b2b second", GW'(valid_o), 14'd1);
        strobe_i = 1'b0;

        // random traffic checked by the model every cycle
        for (int n = 0; n < 3000; n++) begin
            @(posedge clk); #2;
            wheel_code_i    = CWD'($urandom);
            st_msb_i        = 1'($urandom);
            active_wheels_i = CW'($urandom);
            strobe_i        = ($urandom % 3) == 0;
        end
        @(posedge clk); #2 strobe_i = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule